// File: doc/BRIEF.md
# Fall-Through Strobe FIFO

This block is a clocked model of a small fall-through queue that holds sixteen 4-bit words. Writes and reads use level strobes instead of enables. A word is taken on the rising edge of the shift-in strobe. It then moves forward through the storage by itself, one slot per clock, until it reaches the output stage. No read request is needed for this. Two flags report the block's state. `in_ready` means a word can be taken. `out_ready` means a valid word is present on `data_out`.

Both flags pulse between words, and every transfer needs a fresh strobe edge. Because of this, instances chain with plain wires. Connect the upstream `out_ready` and `data_out` to the downstream `shift_in` and `data_in`, and connect the downstream `in_ready` back to the upstream `shift_out`. The chain then acts as one deeper queue. For a wider queue, place instances side by side and AND their flags.

A shift-in strobe may be raised without waiting for `in_ready`. If it is raised while the queue is full and falls before the word is taken, the word is discarded and a sticky `overflow` flag is raised. A synchronous active-high `rst` empties the queue.

Top module: `ripple_fifo`

## Requirements
- R1: One clock after `rst` is sampled high, and until the first word is taken, the outputs are: `in_ready`=1, `out_ready`=0, `data_out`=0, `overflow`=0. Any words held before the reset are gone.
- R2: In an empty queue, a word taken on the clock edge that ends cycle c gives `out_ready`=1 with that word on `data_out` starting in cycle c+16. Cycle c+15 still shows `out_ready`=0.
- R3: A shift-in strobe held high takes exactly one word. `in_ready` reads 0 in the cycle after the word is taken and reads 1 again one cycle later, unless the queue has just become full.
- R4: If `shift_in` rises while `in_ready` is 0 and is then held high, the word is taken on the first cycle in which `in_ready` returns to 1.
- R5: When `out_ready` is 1 and `shift_out` has been low since the last transfer, a high `shift_out` removes one word. In the next cycle `out_ready`=0 and `data_out`=0. A strobe that stays high removes no second word.
- R6: If `shift_out` is already high, and has been low since the last transfer, when a word reaches the output stage, the word is removed at once. `out_ready` is then high for exactly one cycle.
- R7: Words leave in the order they were taken. Sixteen words fill the queue, and `in_ready` stays 0 while it is full.
- R8: A shift-in strobe that rises and falls while the queue is full is ignored and leaves the stored words unchanged. `overflow` goes to 1 in the cycle after the strobe falls and stays at 1 until reset.
- R9: Two instances chained with wires alone behave as a 32-word queue and keep word order.
- R10: Two instances in parallel, with their ready flags ANDed, act as one 8-bit queue and keep the order of the 8-bit words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high master reset |
| shift_in | input | 1 | Shift-in strobe; its rising edge takes `data_in` |
| data_in | input | 4 | Word to be stored |
| in_ready | output | 1 | The input stage is free |
| shift_out | input | 1 | Shift-out strobe; each pulse removes one word |
| data_out | output | 4 | Word in the output stage; 0 while `out_ready` is low |
| out_ready | output | 1 | A valid word is present on `data_out` |
| overflow | output | 1 | Sticky flag: a shift-in was discarded while full |

## Verification
The assertions check four things on every cycle. The stored word count changes only by the words taken in minus the words removed. A word is loaded only into a free input stage. A word is removed only from a filled output stage. A discarded shift-in only ever follows a full cycle.

Some behaviour shows only in the bench scenarios: the 16-cycle fall-through delay, the one-cycle ready pulses, the automatic removal under a held strobe, and the word order through the 32-word chain and the 8-bit parallel pair.

// File: rtl/ftf_pkg.sv
package ftf_pkg;

    localparam int FTF_W     = 4;
    localparam int FTF_DEPTH = 16;

    // one storage position of the ripple chain
    typedef struct packed {
        logic             vld;
        logic [FTF_W-1:0] word;
    } ftf_slot_t;

    localparam ftf_slot_t FTF_EMPTY = '0;

    function automatic ftf_slot_t slot_fill(input logic [FTF_W-1:0] w);
        ftf_slot_t s;
        s.vld  = 1'b1;
        s.word = w;
        return s;
    endfunction

endpackage

// File: rtl/ftf_strobe.sv
// Edge-qualified strobe: a high strobe fires once when the other side is
// ready; it must go low before it can fire again.
module ftf_strobe (
    input  logic clk,
    input  logic rst,
    input  logic strobe,
    input  logic ready,
    output logic fire,
    output logic lapse
);
    logic arm_q;
    logic pend_q;

    assign fire  = strobe & arm_q & ready;
    // a pulse that was waiting and has now ended without a transfer
    assign lapse = pend_q & ~strobe;

    always_ff @(posedge clk) begin
        if (rst) begin
            arm_q  <= 1'b1;
            pend_q <= 1'b0;
        end else begin
            if (fire)
                arm_q <= 1'b0;
            else if (!strobe)
                arm_q <= 1'b1;
            pend_q <= strobe & arm_q & ~ready;
        end
    end
endmodule

// File: rtl/ftf_chain.sv
// Storage: words advance one position per clock toward the last slot
// whenever the slot ahead is free or is emptying in the same cycle.
module ftf_chain
    import ftf_pkg::*;
#(
    parameter int DEPTH = FTF_DEPTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [FTF_W-1:0] load_word,
    input  logic             unload,
    output logic             head_busy,
    output logic             tail_vld,
    output logic [FTF_W-1:0] tail_word,
    output logic             full
);
    localparam int LAST = DEPTH - 1;

    ftf_slot_t        slot_q [DEPTH];
    ftf_slot_t        slot_d [DEPTH];
    ftf_slot_t        src    [DEPTH];
    logic [DEPTH-1:0] vld_vec;
    logic [DEPTH-1:0] recv;
    logic [DEPTH-1:0] mv;

    for (genvar g = 0; g < DEPTH; g++) begin : g_link
        assign vld_vec[g] = slot_q[g].vld;
        if (g == 0) begin : g_head
            assign recv[g] = load;
            assign src[g]  = slot_fill(load_word);
        end else begin : g_body
            assign recv[g] = mv[g-1];
            assign src[g]  = slot_q[g-1];
        end
    end

    // advance chain, resolved from the output end backward
    always_comb begin
        logic nxt;
        mv       = '0;
        mv[LAST] = unload;
        nxt      = unload;
        for (int i = LAST - 1; i >= 0; i--) begin
            nxt   = vld_vec[i] & (~vld_vec[i+1] | nxt);
            mv[i] = nxt;
        end
    end

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            slot_d[i] = slot_q[i];
            if (recv[i])
                slot_d[i] = src[i];
            else if (mv[i])
                slot_d[i] = FTF_EMPTY;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++)
                slot_q[i] <= FTF_EMPTY;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign head_busy = vld_vec[0];
    assign tail_vld  = vld_vec[LAST];
    assign tail_word = slot_q[LAST].word;
    assign full      = &vld_vec;

    // R7
    word_count_chk: assert property (@(posedge clk) disable iff (rst)
        (load || !load) |=> int'($countones(vld_vec)) ==
            int'($countones($past(vld_vec))) + int'($past(load)) - int'($past(unload)));

    // R3
    load_free_chk: assert property (@(posedge clk) disable iff (rst)
        load |-> !vld_vec[0]);

    // R5
    unload_filled_chk: assert property (@(posedge clk) disable iff (rst)
        unload |-> vld_vec[LAST]);
endmodule

// File: rtl/ripple_fifo.sv
module ripple_fifo
    import ftf_pkg::*;
#(
    parameter int DEPTH = FTF_DEPTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shift_in,
    input  logic [FTF_W-1:0] data_in,
    output logic             in_ready,
    input  logic             shift_out,
    output logic [FTF_W-1:0] data_out,
    output logic             out_ready
    ,
    output logic             overflow
);
    logic             head_busy;
    logic             tail_vld;
    logic             full;
    logic [FTF_W-1:0] tail_word;
    logic             in_fire;
    logic             in_lapse;
    logic             out_fire;
    logic             out_lapse_unused;
    logic             gap_q;
    logic             ovf_q;

    assign in_ready = ~head_busy;
    // the output stage reads empty for one cycle after each removal
    assign out_ready = tail_vld & ~gap_q;
    assign data_out  = out_ready ? tail_word : '0;
    assign overflow  = ovf_q;

    ftf_strobe u_in_strobe (
        .clk    (clk),
        .rst    (rst),
        .strobe (shift_in),
        .ready  (in_ready),
        .fire   (in_fire),
        .lapse  (in_lapse)
    );

    ftf_strobe u_out_strobe (
        .clk    (clk),
        .rst    (rst),
        .strobe (shift_out),
        .ready  (out_ready),
        .fire   (out_fire),
        .lapse  (out_lapse_unused)
    );

    ftf_chain #(.DEPTH(DEPTH)) u_chain (
        .clk       (clk),
        .rst       (rst),
        .load      (in_fire),
        .load_word (data_in),
        .unload    (out_fire),
        .head_busy (head_busy),
        .tail_vld  (tail_vld),
        .tail_word (tail_word),
        .full      (full)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q <= 1'b0;
            ovf_q <= 1'b0;
        end else begin
            gap_q <= out_fire;
            ovf_q <= ovf_q | in_lapse;
        end
    end

    // R3
    in_drop_chk: assert property (@(posedge clk) disable iff (rst)
        in_fire |=> !in_ready);

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        in_lapse |-> $past(full));
endmodule

// File: tb/ripple_fifo_test.sv
module ripple_fifo_test;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst;
    int   checks = 0;
    int   fails  = 0;
    bit   done   = 1'b0;

    localparam logic [3:0] FILL_TAB [16] = '{
        4'h3, 4'hA, 4'h0, 4'hF, 4'h5, 4'hC, 4'h1, 4'h8,
        4'h7, 4'hE, 4'h2, 4'h9, 4'hB, 4'h4, 4'hD, 4'h6
    };

    // single instance
    logic       u_si, u_so, u_ir, u_or, u_ovf;
    logic [3:0] u_din, u_dout;

    ripple_fifo uut (
        .clk(clk), .rst(rst), .shift_in(u_si), .data_in(u_din), .in_ready(u_ir),
        .shift_out(u_so), .data_out(u_dout), .out_ready(u_or), .overflow(u_ovf)
    );

    // two-deep chain
    logic       ca_si, ca_ir, link_rdy, cb_ir, cb_so, cb_or, ca_ovf, cb_ovf;
    logic [3:0] ca_din, link_data, cb_dout;

    ripple_fifo u_ca (
        .clk(clk), .rst(rst), .shift_in(ca_si), .data_in(ca_din), .in_ready(ca_ir),
        .shift_out(cb_ir), .data_out(link_data), .out_ready(link_rdy), .overflow(ca_ovf)
    );
    ripple_fifo u_cb (
        .clk(clk), .rst(rst), .shift_in(link_rdy), .data_in(link_data), .in_ready(cb_ir),
        .shift_out(cb_so), .data_out(cb_dout), .out_ready(cb_or), .overflow(cb_ovf)
    );

    // parallel pair
    logic       w_si, w_so, w_ir0, w_ir1, w_or0, w_or1, w_ovf0, w_ovf1;
    logic [7:0] w_din, w_dout;
    logic       w_ir, w_or;
    assign w_ir = w_ir0 & w_ir1;
    assign w_or = w_or0 & w_or1;

    ripple_fifo u_wl (
        .clk(clk), .rst(rst), .shift_in(w_si), .data_in(w_din[3:0]), .in_ready(w_ir0),
        .shift_out(w_so), .data_out(w_dout[3:0]), .out_ready(w_or0), .overflow(w_ovf0)
    );
    ripple_fifo u_wh (
        .clk(clk), .rst(rst), .shift_in(w_si), .data_in(w_din[7:4]), .in_ready(w_ir1),
        .shift_out(w_so), .data_out(w_dout[7:4]), .out_ready(w_or1), .overflow(w_ovf1)
    );

    task automatic tick;
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic pop_uut(input string req, input logic [3:0] exp);
        for (int t = 0; t < 40 && !u_or; t++) tick();
        check({req, " out_ready"}, 8'(u_or), 8'h1);
        check({req, " data"}, 8'(u_dout), 8'(exp));
        u_so = 1'b1;
        tick();
        u_so = 1'b0;
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        u_si = 0; u_so = 0; u_din = 0;
        ca_si = 0; ca_din = 0; cb_so = 0;
        w_si = 0; w_so = 0; w_din = 0;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1 reset state
        check("R1 in_ready", 8'(u_ir), 8'h1);
        check("R1 out_ready", 8'(u_or), 8'h0);
        check("R1 data_out", 8'(u_dout), 8'h0);
        check("R1 overflow", 8'(u_ovf), 8'h0);

        // R2 latency, R3 single capture under a held strobe
        u_si = 1'b1; u_din = 4'h5;
        for (int k = 1; k <= 16; k++) begin
            tick();
            if (k == 1)  check("R3 in_ready low after take", 8'(u_ir), 8'h0);
            if (k == 2)  check("R3 in_ready back high", 8'(u_ir), 8'h1);
            if (k == 15) check("R2 not yet at output", 8'(u_or), 8'h0);
            if (k == 16) begin
                check("R2 out_ready at c+16", 8'(u_or), 8'h1);
                check("R2 data at c+16", 8'(u_dout), 8'h5);
            end
        end
        u_si = 1'b0;
        u_so = 1'b1;
        tick();
        u_so = 1'b0;
        check("R5 out_ready low after removal", 8'(u_or), 8'h0);
        check("R5 data zero after removal", 8'(u_dout), 8'h0);
        repeat (20) tick();
        check("R3 held strobe took one word", 8'(u_or), 8'h0);

        // R6 automatic removal under a held shift_out
        u_so = 1'b1;
        u_si = 1'b1; u_din = 4'h9;
        for (int k = 1; k <= 17; k++) begin
            tick();
            if (k == 1) u_si = 1'b0;
            if (k == 16) begin
                check("R6 pulse high", 8'(u_or), 8'h1);
                check("R6 pulse data", 8'(u_dout), 8'h9);
            end
            if (k == 17) check("R6 pulse one cycle", 8'(u_or), 8'h0);
        end
        // R5 strobe still high: next word must stay
        u_si = 1'b1; u_din = 4'h4;
        for (int k = 1; k <= 20; k++) begin
            tick();
            if (k == 1) u_si = 1'b0;
        end
        check("R5 word stays under old strobe", 8'(u_or), 8'h1);
        check("R5 word data", 8'(u_dout), 8'h4);
        u_so = 1'b0;
        tick();
        u_so = 1'b1;
        tick();
        u_so = 1'b0;
        check("R5 new strobe removes word", 8'(u_or), 8'h0);
        repeat (5) tick();
        check("R5 queue empty", 8'(u_or), 8'h0);

        // R7 table-driven fill
        for (int i = 0; i < 16; i++) begin
            u_si = 1'b1; u_din = FILL_TAB[i];
            tick();
            u_si = 1'b0;
            tick();
        end
        repeat (20) tick();
        check("R7 full blocks input", 8'(u_ir), 8'h0);
        check("R7 head word", 8'(u_dout), 8'(FILL_TAB[0]));

        // R8 overflow pulse while full
        u_si = 1'b1; u_din = 4'hE;
        tick();
        u_si = 1'b0;
        check("R8 overflow not yet", 8'(u_ovf), 8'h0);
        tick();
        check("R8 overflow raised", 8'(u_ovf), 8'h1);
        check("R8 still full", 8'(u_ir), 8'h0);
        check("R8 head unchanged", 8'(u_dout), 8'(FILL_TAB[0]));

        // R4 held strobe waits for room
        u_si = 1'b1; u_din = 4'h6;
        tick();
        u_so = 1'b1;
        tick();
        u_so = 1'b0;
        repeat (4) tick();
        u_si = 1'b0;
        check("R4 waiting word taken", 8'(u_ir), 8'h0);

        for (int i = 1; i < 16; i++) pop_uut("R7 order", FILL_TAB[i]);
        pop_uut("R4 late word", 4'h6);
        repeat (30) tick();
        check("R8 dropped word absent", 8'(u_or), 8'h0);
        check("R8 empty data", 8'(u_dout), 8'h0);
        check("R8 overflow sticky", 8'(u_ovf), 8'h1);

        // R1 reset in mid-run
        u_si = 1'b1; u_din = 4'hB;
        tick();
        u_si = 1'b0;
        repeat (5) tick();
        rst = 1'b1;
        tick();
        rst = 1'b0;
        tick();
        check("R1 overflow cleared", 8'(u_ovf), 8'h0);
        check("R1 in_ready after reset", 8'(u_ir), 8'h1);
        repeat (20) tick();
        check("R1 word cleared", 8'(u_or), 8'h0);

        // R9 two-deep chain
        for (int i = 0; i < 32; i++) begin
            for (int t = 0; t < 100 && !ca_ir; t++) tick();
            ca_si = 1'b1; ca_din = 4'((i * 7 + 1) % 16);
            tick();
            ca_si = 1'b0;
            tick();
        end
        repeat (80) tick();
        check("R9 chain full at 32", 8'(ca_ir), 8'h0);
        for (int i = 0; i < 32; i++) begin
            for (int t = 0; t < 100 && !cb_or; t++) tick();
            check("R9 chain out_ready", 8'(cb_or), 8'h1);
            check("R9 chain order", 8'(cb_dout), 8'((i * 7 + 1) % 16));
            cb_so = 1'b1;
            tick();
            cb_so = 1'b0;
            tick();
        end
        repeat (80) tick();
        check("R9 chain drained", 8'(cb_or), 8'h0);

        // R10 parallel pair
        for (int i = 0; i < 16; i++) begin
            for (int t = 0; t < 100 && !w_ir; t++) tick();
            w_si = 1'b1; w_din = 8'((i * 37 + 5) % 256);
            tick();
            w_si = 1'b0;
            tick();
        end
        repeat (20) tick();
        check("R10 pair full", 8'(w_ir), 8'h0);
        for (int i = 0; i < 16; i++) begin
            for (int t = 0; t < 100 && !w_or; t++) tick();
            check("R10 pair order", w_dout, 8'((i * 37 + 5) % 256));
            w_so = 1'b1;
            tick();
            w_so = 1'b0;
            tick();
        end
        repeat (20) tick();
        check("R10 pair drained", 8'(w_or), 8'h0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule